// File: doc/BRIEF.md
# Radio Transceiver Power-Mode Sequencer

This block is the control state machine that drives the power and reset controls of a radio transceiver. After reset it releases the reset line and starts the crystal oscillator. It waits for the oscillator to settle, then holds for a short configuration window before it reaches standby. From standby, register writes from the baseband start a transmit or receive sequence, or put the radio to sleep. Every delay is a parameter counted in clock cycles.

The transmit sequence works in four steps. The synthesizer comes up first. After a settle delay the transmit path comes up, with the power amplifier still off. The power amplifier is enabled only once the baseband raises its data line. On shutdown the amplifier drops first, and the synthesizer and transmit path follow a fixed gap later. The receive sequence brings up the synthesizer, then the receive path after a delay. Its DC estimator mode flag starts in the fast access-code setting and moves to payload mode on a sync-word timer or a packet-control input, whichever comes first.

Sleep turns off the oscillator but keeps the reset released, so configuration survives. When sleep is entered from an active state, the powered radio paths are left as they were. A write that asks for transmit and receive together is dropped and sets a sticky error flag.

Top module: `rf_pwr_seq`

## Requirements
- R1: While `rst` is high at a clock edge, every output is 0 after that edge. At the first edge with `rst` low, `clr_rel` and `osc_on` rise and stay high.
- R2: After reset, the sequencer waits with only `clr_rel`/`osc_on` high until `osc_ok` is 1 at an edge. It then holds for HOLD_CYC cycles before standby. Register writes are ignored throughout this start-up (no path output changes).
- R3: In standby only `clr_rel` and `osc_on` are high. An accepted write with `wr_sleep`=1 enters sleep at the next edge: `osc_on` falls and `clr_rel` stays 1.
- R4: In sleep, an accepted write with `wr_sleep`=0 raises `osc_on` at the next edge. Standby is reached at the first edge with `osc_ok`=1, and there any path powers held through sleep are cleared.
- R5: Sleep entered from a transmit or receive state leaves `synth_on`, `tx_on`, `pa_on` and `rx_on` at their values; only `osc_on` falls and `dc_payload` clears.
- R6: In standby, a write with `wr_tx`=1, `wr_rx`=0, `wr_sleep`=0 raises `synth_on` at the next edge, and `tx_on` rises SYNTH_CYC cycles later with `pa_on` still 0. `tx_on` and `rx_on` are never high together.
- R7: With `tx_on` high, the first edge at which `bb_data` is 1 after being 0 at the previous edge raises `pa_on`. `pa_on` is never high without `tx_on`.
- R8: In transmit-data state, a write with `wr_tx`=0 drops `pa_on` at the next edge, and `synth_on`/`tx_on` fall GAP_CYC cycles later (standby). The same write before the amplifier is on drops `synth_on`/`tx_on` at the next edge.
- R9: In standby, a write with `wr_rx`=1, `wr_tx`=0, `wr_sleep`=0 raises `synth_on` at the next edge, and `rx_on` rises RX_DLY_CYC cycles later with `dc_payload`=0.
- R10: `dc_payload` rises SYNCW_CYC cycles after `rx_on` rises, or earlier at the first later edge with `pkt_mark`=1. It then stays high until the receive-data state is left, and is only high with `rx_on`.
- R11: A write with `wr_rx`=0 during the receive delay or receive data drops `synth_on`, `rx_on` and `dc_payload` at the next edge (standby).
- R12: A write with `wr_tx`=1 and `wr_rx`=1 is ignored in every state and sets `err_both` at the next edge; `err_both` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_ok | input | 1 | Oscillator settled flag |
| wr_stb | input | 1 | Register write strobe |
| wr_tx | input | 1 | Requested transmit enable carried by the write |
| wr_rx | input | 1 | Requested receive enable carried by the write |
| wr_sleep | input | 1 | Sleep request carried by the write |
| bb_data | input | 1 | Baseband data line, a rising edge starts TX sync |
| pkt_mark | input | 1 | Packet-control input ending the sync word early |
| clr_rel | output | 1 | Reset release to the radio circuits |
| osc_on | output | 1 | Oscillator power |
| synth_on | output | 1 | Synthesizer power |
| tx_on | output | 1 | Transmit path power (without amplifier) |
| pa_on | output | 1 | Power amplifier power |
| rx_on | output | 1 | Receive path power |
| dc_payload | output | 1 | DC estimation mode, 0 access code, 1 payload |
| err_both | output | 1 | Sticky flag for a write asking for TX and RX together |

## Verification
Every output is registered. A write, an `osc_ok` level, a `bb_data` rise or a `pkt_mark` pulse sampled at one edge therefore shows at the outputs right after that same edge. Timer-driven changes land exactly HOLD_CYC, SYNTH_CYC, GAP_CYC, RX_DLY_CYC or SYNCW_CYC edges after the edge that entered the timed state. The bench drives inputs at the falling edge and advances a behavioural model at each rising edge. That model counts edges spent in each phase with plain integers. At the next falling edge the bench compares all eight outputs with the model, so each result is checked in the very cycle it is due. A few directed checks add fixed-point expectations for start-up and for sleep entered from transmit.

// File: rtl/rf_pwr_pkg.sv
package rf_pwr_pkg;

  typedef enum logic [3:0] {
    ST_OFF,
    ST_OSC_UP,
    ST_HOLD,
    ST_IDLE,
    ST_SLEEP,
    ST_WAKE,
    ST_TX_SYN,
    ST_TX_SYNC,
    ST_TX_ON,
    ST_TX_GAP,
    ST_RX_SYN,
    ST_RX_ON
  } seq_st_e;

  typedef struct packed {
    logic synth;
    logic tx;
    logic pa;
    logic rx;
  } path_pwr_t;

endpackage

// File: rtl/rf_dly_cnt.sv
module rf_dly_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

  // timed delays of R6/R8/R9/R10 rely on one step per cycle
  assert_cnt_step_R6: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/rf_rise_det.sv
module rf_rise_det (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);

  logic din_q;

  always_ff @(posedge clk) begin
    if (rst) din_q <= 1'b0;
    else     din_q <= din;
  end

  assign rise = din & ~din_q;

endmodule

// File: rtl/rf_pwr_dec.sv
module rf_pwr_dec
  import rf_pwr_pkg::*;
(
  input  seq_st_e   st,
  input  path_pwr_t held,
  output logic      clr,
  output logic      osc,
  output path_pwr_t path
);

  always_comb begin
    clr  = 1'b1;
    osc  = 1'b1;
    path = '0;
    case (st)
      ST_OFF: begin
        clr = 1'b0;
        osc = 1'b0;
      end
      ST_SLEEP: begin
        osc  = 1'b0;
        path = held;
      end
      ST_WAKE:    path = held;
      ST_TX_SYN:  path.synth = 1'b1;
      ST_TX_SYNC: begin
        path.synth = 1'b1;
        path.tx    = 1'b1;
      end
      ST_TX_ON: begin
        path.synth = 1'b1;
        path.tx    = 1'b1;
        path.pa    = 1'b1;
      end
      ST_TX_GAP: begin
        path.synth = 1'b1;
        path.tx    = 1'b1;
      end
      ST_RX_SYN:  path.synth = 1'b1;
      ST_RX_ON: begin
        path.synth = 1'b1;
        path.rx    = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/rf_pwr_seq.sv
module rf_pwr_seq
  import rf_pwr_pkg::*;
#(
  parameter int HOLD_CYC   = 16,
  parameter int SYNTH_CYC  = 12000,
  parameter int GAP_CYC    = 100,
  parameter int RX_DLY_CYC = 17500,
  parameter int SYNCW_CYC  = 7200
) (
  input  logic clk,
  input  logic rst,
  input  logic osc_ok,
  input  logic wr_stb,
  input  logic wr_tx,
  input  logic wr_rx,
  input  logic wr_sleep,
  input  logic bb_data,
  input  logic pkt_mark,
  output logic clr_rel,
  output logic osc_on,
  output logic synth_on,
  output logic tx_on,
  output logic pa_on,
  output logic rx_on,
  output logic dc_payload,
  output logic err_both
);

  localparam int MAX_A = (HOLD_CYC > SYNTH_CYC) ? HOLD_CYC : SYNTH_CYC;
  localparam int MAX_B = (GAP_CYC > RX_DLY_CYC) ? GAP_CYC : RX_DLY_CYC;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_D = (MAX_C > SYNCW_CYC) ? MAX_C : SYNCW_CYC;
  localparam int CW    = $clog2(MAX_D + 1);

  localparam logic [CW-1:0] LD_HOLD  = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] LD_SYNTH = CW'(SYNTH_CYC - 1);
  localparam logic [CW-1:0] LD_GAP   = CW'(GAP_CYC - 1);
  localparam logic [CW-1:0] LD_RXDLY = CW'(RX_DLY_CYC - 1);
  localparam logic [CW-1:0] LD_SYNCW = CW'(SYNCW_CYC - 1);

  seq_st_e   state, nxt;
  path_pwr_t held, held_n, path_n;
  logic      clr_n, osc_n, dc_n;
  logic      cnt_done, bb_rise;
  logic      cnt_load;
  logic [CW-1:0] cnt_val;

  logic wr_bad, wr_ok, wr_go_sleep;
  assign wr_bad      = wr_stb & wr_tx & wr_rx;
  assign wr_ok       = wr_stb & ~wr_bad;
  assign wr_go_sleep = wr_ok & wr_sleep;

  rf_dly_cnt #(.W(CW)) u_dly (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .load_val (cnt_val),
    .expired  (cnt_done)
  );

  rf_rise_det u_rise (
    .clk  (clk),
    .rst  (rst),
    .din  (bb_data),
    .rise (bb_rise)
  );

  // next state: writes outrank timers and data edges
  always_comb begin
    nxt = state;
    case (state)
      ST_OFF:    nxt = ST_OSC_UP;
      ST_OSC_UP: if (osc_ok) nxt = ST_HOLD;
      ST_HOLD:   if (cnt_done) nxt = ST_IDLE;
      ST_IDLE: begin
        if (wr_go_sleep)        nxt = ST_SLEEP;
        else if (wr_ok && wr_tx) nxt = ST_TX_SYN;
        else if (wr_ok && wr_rx) nxt = ST_RX_SYN;
      end
      ST_SLEEP:  if (wr_ok && !wr_sleep) nxt = ST_WAKE;
      ST_WAKE:   if (osc_ok) nxt = ST_IDLE;
      ST_TX_SYN: begin
        if (wr_go_sleep)          nxt = ST_SLEEP;
        else if (wr_ok && !wr_tx) nxt = ST_IDLE;
        else if (cnt_done)        nxt = ST_TX_SYNC;
      end
      ST_TX_SYNC: begin
        if (wr_go_sleep)          nxt = ST_SLEEP;
        else if (wr_ok && !wr_tx) nxt = ST_IDLE;
        else if (bb_rise)         nxt = ST_TX_ON;
      end
      ST_TX_ON: begin
        if (wr_go_sleep)          nxt = ST_SLEEP;
        else if (wr_ok && !wr_tx) nxt = ST_TX_GAP;
      end
      ST_TX_GAP: begin
        if (wr_go_sleep)   nxt = ST_SLEEP;
        else if (cnt_done) nxt = ST_IDLE;
      end
      ST_RX_SYN: begin
        if (wr_go_sleep)          nxt = ST_SLEEP;
        else if (wr_ok && !wr_rx) nxt = ST_IDLE;
        else if (cnt_done)        nxt = ST_RX_ON;
      end
      ST_RX_ON: begin
        if (wr_go_sleep)          nxt = ST_SLEEP;
        else if (wr_ok && !wr_rx) nxt = ST_IDLE;
      end
      default: nxt = ST_OFF;
    endcase
  end

  // delay reload on every state entry
  always_comb begin
    cnt_load = (nxt != state);
    case (nxt)
      ST_HOLD:   cnt_val = LD_HOLD;
      ST_TX_SYN: cnt_val = LD_SYNTH;
      ST_TX_GAP: cnt_val = LD_GAP;
      ST_RX_SYN: cnt_val = LD_RXDLY;
      ST_RX_ON:  cnt_val = LD_SYNCW;
      default:   cnt_val = '0;
    endcase
  end

  always_comb begin
    if (nxt == ST_SLEEP && state != ST_SLEEP)
      held_n = '{synth: synth_on, tx: tx_on, pa: pa_on, rx: rx_on};
    else
      held_n = held;
  end

  rf_pwr_dec u_dec (
    .st   (nxt),
    .held (held_n),
    .clr  (clr_n),
    .osc  (osc_n),
    .path (path_n)
  );

  assign dc_n = (nxt == ST_RX_ON) && (state == ST_RX_ON) &&
                (dc_payload | pkt_mark | cnt_done);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_OFF;
      held       <= '0;
      clr_rel    <= 1'b0;
      osc_on     <= 1'b0;
      synth_on   <= 1'b0;
      tx_on      <= 1'b0;
      pa_on      <= 1'b0;
      rx_on      <= 1'b0;
      dc_payload <= 1'b0;
      err_both   <= 1'b0;
    end else begin
      state      <= nxt;
      held       <= held_n;
      clr_rel    <= clr_n;
      osc_on     <= osc_n;
      synth_on   <= path_n.synth;
      tx_on      <= path_n.tx;
      pa_on      <= path_n.pa;
      rx_on      <= path_n.rx;
      dc_payload <= dc_n;
      err_both   <= err_both | wr_bad;
    end
  end

  assert_reset_off_R1: assert property (@(posedge clk)
    rst |=> (!clr_rel && !osc_on && !synth_on && !pa_on && !err_both));

  assert_sleep_osc_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SLEEP) |-> (!osc_on && clr_rel));

  assert_txrx_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(tx_on && rx_on));

  assert_pa_needs_tx_R7: assert property (@(posedge clk) disable iff (rst)
    pa_on |-> (tx_on && synth_on));

  assert_pa_first_off_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == ST_TX_ON && $fell(pa_on)) |-> (tx_on && synth_on));

  assert_dc_in_rx_R10: assert property (@(posedge clk) disable iff (rst)
    dc_payload |-> rx_on);

  assert_err_sticky_R12: assert property (@(posedge clk) disable iff (rst)
    err_both |=> err_both);

endmodule

// File: tb/rf_pwr_seq_bench.sv
module rf_pwr_seq_bench;

  localparam int HOLD  = 3;
  localparam int SYNTH = 6;
  localparam int GAP   = 4;
  localparam int RXD   = 5;
  localparam int SYNCW = 7;

  localparam int P_OFF = 0, P_OSC = 1, P_HOLD = 2, P_IDLE = 3, P_SLP = 4,
                 P_WAKE = 5, P_TXW = 6, P_TXS = 7, P_TXD = 8, P_GAP = 9,
                 P_RXW = 10, P_RXD = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic osc_ok = 1'b0, wr_stb = 1'b0, wr_tx = 1'b0, wr_rx = 1'b0, wr_sleep = 1'b0;
  logic bb_data = 1'b0, pkt_mark = 1'b0;
  logic clr_rel, osc_on, synth_on, tx_on, pa_on, rx_on, dc_payload, err_both;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rf_pwr_seq #(
    .HOLD_CYC(HOLD), .SYNTH_CYC(SYNTH), .GAP_CYC(GAP),
    .RX_DLY_CYC(RXD), .SYNCW_CYC(SYNCW)
  ) u_rf_pwr_seq (
    .clk(clk), .rst(rst), .osc_ok(osc_ok), .wr_stb(wr_stb), .wr_tx(wr_tx),
    .wr_rx(wr_rx), .wr_sleep(wr_sleep), .bb_data(bb_data), .pkt_mark(pkt_mark),
    .clr_rel(clr_rel), .osc_on(osc_on), .synth_on(synth_on), .tx_on(tx_on),
    .pa_on(pa_on), .rx_on(rx_on), .dc_payload(dc_payload), .err_both(err_both)
  );

  // behavioural reference: phase code plus edges spent in the phase
  int ph = P_OFF;
  int t  = 0;
  bit m_clr, m_osc, m_s, m_t, m_p, m_r, m_dc, m_err;
  bit h_s, h_t, h_p, h_r;
  bit prev_bd;

  always @(posedge clk) begin : model
    bit bad, ok, rise;
    int nph;
    if (rst) begin
      ph = P_OFF; t = 0; prev_bd = 0;
      {m_clr, m_osc, m_s, m_t, m_p, m_r, m_dc, m_err} = '0;
      {h_s, h_t, h_p, h_r} = '0;
    end else begin
      bad  = wr_stb && wr_tx && wr_rx;
      ok   = wr_stb && !bad;
      rise = bb_data && !prev_bd;
      if (bad) m_err = 1;
      t   = t + 1;
      nph = ph;
      if (ok && wr_sleep && ph >= P_IDLE && ph != P_SLP && ph != P_WAKE)
        nph = P_SLP;
      else begin
        case (ph)
          P_OFF:  nph = P_OSC;
          P_OSC:  if (osc_ok) nph = P_HOLD;
          P_HOLD: if (t == HOLD) nph = P_IDLE;
          P_IDLE: if (ok && wr_tx) nph = P_TXW; else if (ok && wr_rx) nph = P_RXW;
          P_SLP:  if (ok && !wr_sleep) nph = P_WAKE;
          P_WAKE: if (osc_ok) nph = P_IDLE;
          P_TXW:  if (ok && !wr_tx) nph = P_IDLE; else if (t == SYNTH) nph = P_TXS;
          P_TXS:  if (ok && !wr_tx) nph = P_IDLE; else if (rise) nph = P_TXD;
          P_TXD:  if (ok && !wr_tx) nph = P_GAP;
          P_GAP:  if (t == GAP) nph = P_IDLE;
          P_RXW:  if (ok && !wr_rx) nph = P_IDLE; else if (t == RXD) nph = P_RXD;
          P_RXD:  if (ok && !wr_rx) nph = P_IDLE;
          default: nph = P_OFF;
        endcase
      end
      if (ph == P_RXD && nph == P_RXD) m_dc = m_dc || pkt_mark || (t >= SYNCW);
      else m_dc = 0;
      if (nph == P_SLP && ph != P_SLP) begin
        h_s = m_s; h_t = m_t; h_p = m_p; h_r = m_r;
      end
      if (nph != ph) t = 0;
      ph = nph;
      m_clr = 1; m_osc = 1; {m_s, m_t, m_p, m_r} = '0;
      case (ph)
        P_SLP:  begin m_osc = 0; {m_s, m_t, m_p, m_r} = {h_s, h_t, h_p, h_r}; end
        P_WAKE: {m_s, m_t, m_p, m_r} = {h_s, h_t, h_p, h_r};
        P_TXW:  m_s = 1;
        P_TXS:  begin m_s = 1; m_t = 1; end
        P_TXD:  begin m_s = 1; m_t = 1; m_p = 1; end
        P_GAP:  begin m_s = 1; m_t = 1; end
        P_RXW:  m_s = 1;
        P_RXD:  begin m_s = 1; m_r = 1; end
        default: ;
      endcase
      prev_bd = bb_data;
    end
  end

  task automatic chk(input bit act, input bit exp, input string what, input string rq);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", rq, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk(clr_rel,    m_clr, "clr_rel",    "R1");
      chk(osc_on,     m_osc, "osc_on",     "R3_R4");
      chk(synth_on,   m_s,   "synth_on",   "R6_R9");
      chk(tx_on,      m_t,   "tx_on",      "R6_R8");
      chk(pa_on,      m_p,   "pa_on",      "R7_R8");
      chk(rx_on,      m_r,   "rx_on",      "R9_R11");
      chk(dc_payload, m_dc,  "dc_payload", "R10");
      chk(err_both,   m_err, "err_both",   "R12");
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit tx, input bit rx, input bit sl);
    @(negedge clk);
    wr_stb = 1; wr_tx = tx; wr_rx = rx; wr_sleep = sl;
    @(negedge clk);
    wr_stb = 0; wr_tx = 0; wr_rx = 0; wr_sleep = 0;
  endtask

  task automatic tx_up();
    wr(1, 0, 0);
    cyc(SYNTH + 2);
    bb_data = 1;
    cyc(3);
    bb_data = 0;
  endtask

  initial begin : stim
    cyc(3);
    rst = 0;
    // R2: start-up waits for osc_ok, writes ignored meanwhile
    cyc(4);
    wr(1, 0, 0);
    chk(synth_on, 1'b0, "startup write ignored", "R2");
    chk(osc_on,   1'b1, "startup osc on", "R2");
    osc_ok = 1;
    cyc(1);
    wr(0, 0, 1);
    chk(osc_on, 1'b1, "hold write ignored", "R2");
    cyc(HOLD + 2);
    // R12: both enables requested in standby
    wr(1, 1, 0);
    cyc(2);
    // R6 R7 R8: full transmit with amplifier gap
    tx_up();
    cyc(2);
    wr(0, 0, 0);
    cyc(GAP + 3);
    // R8: abort before the amplifier comes on
    wr(1, 0, 0);
    cyc(2);
    wr(0, 0, 0);
    cyc(2);
    // data edge during synth settle is not a sync edge
    wr(1, 0, 0);
    bb_data = 1;
    cyc(SYNTH + 3);
    bb_data = 0;
    cyc(2);
    bb_data = 1;
    cyc(2);
    bb_data = 0;
    wr(0, 0, 0);
    cyc(GAP + 2);
    // R9 R10 R11: receive, timer switches DC mode
    wr(0, 1, 0);
    cyc(RXD + SYNCW + 4);
    wr(1, 1, 0);
    cyc(1);
    wr(0, 0, 0);
    cyc(2);
    // R10: packet-control input ends the sync word early
    wr(0, 1, 0);
    cyc(RXD + 2);
    pkt_mark = 1;
    cyc(1);
    pkt_mark = 0;
    cyc(3);
    wr(1, 0, 0);
    cyc(2);
    // R11: stop during the receive delay
    wr(0, 1, 0);
    cyc(2);
    wr(0, 0, 0);
    cyc(2);
    // R3 R4: sleep from standby, slow oscillator on wake
    wr(0, 0, 1);
    cyc(3);
    osc_ok = 0;
    wr(0, 0, 0);
    cyc(4);
    osc_ok = 1;
    cyc(3);
    // R5: sleep from transmit keeps the radio paths
    tx_up();
    wr(0, 0, 1);
    chk(pa_on,  1'b1, "pa kept in sleep", "R5");
    chk(tx_on,  1'b1, "tx kept in sleep", "R5");
    chk(osc_on, 1'b0, "osc off in sleep", "R5");
    cyc(3);
    wr(0, 0, 0);
    cyc(3);
    // R5: sleep from receive data
    wr(0, 1, 0);
    cyc(RXD + SYNCW + 2);
    wr(0, 1, 1);
    chk(rx_on,      1'b1, "rx kept in sleep", "R5");
    chk(dc_payload, 1'b0, "dc cleared in sleep", "R5");
    cyc(2);
    wr(0, 0, 0);
    cyc(3);
    // R1: reset again clears the sticky flag
    @(negedge clk);
    rst = 1;
    cyc(2);
    chk(err_both, 1'b0, "err cleared by reset", "R1");
    chk(clr_rel,  1'b0, "clr low in reset", "R1");
    rst = 0;
    cyc(3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule